// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block watches the command pins of a DDR SDRAM interface (clock enable, chip select, row strobe, column strobe, write enable, bank address and address) on every rising clock edge. It turns each sampled pin pattern into one command code and reports it one cycle later. It also keeps the idle or open state of each bank, the row held open in each bank, and the power mode of the device. It sits beside a memory controller or on a monitor path. Its job is to flag any command that is not allowed in the present state of the banks.

Each cycle, one command is judged against the full bank map. The block also enforces four rules: the all-idle rule for mode set, refresh and self refresh; the two-cycle quiet gap after a mode set; the burst window that follows a read or write with auto precharge; and the precharge-all override of the bank address. An illegal command raises a one-cycle error flag. It leaves the banks, the open rows and the timing counters exactly as they were.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: During and after reset, all banks are idle, `cmd_code` is 0 (NOP), `cmd_err` is 0 and `pwr_mode` is 0 (running).
- R2: With clock enable high in this cycle and the previous one, a sampled `cs_n` of 1 is reported as DESELECT (code 1), whatever the strobes are. It never raises an error and changes no bank.
- R3: Commands are reported one cycle after the edge that samples them. With clock enable high on both cycles and `cs_n` low, the value {ras_n,cas_n,we_n} decodes as follows: 000 is MRS (2), 001 is REFRESH (3), 010 is PRECHARGE (12) or PRECHARGE-ALL (13) when addr[10] is set, 011 is ACTIVATE (6), 100 is WRITE (9) or WRITE-AP (10), 101 is READ (7) or READ-AP (8), 110 is BURST-STOP (11) and 111 is NOP (0).
- R4: The bank index is {ba[0],ba[1]}: ba=00 selects bank 0, 10 selects bank 1, 01 selects bank 2 and 11 selects bank 3. A legal ACTIVATE sets `bank_open[index]` and stores addr in `open_rows[index*13 +: 13]`.
- R5: An ACTIVATE to a bank that is already open is illegal.
- R6: An illegal command gives `cmd_err`=1 for the cycle in which it is reported. Bank states, open rows and the wait counters stay unchanged.
- R7: MRS, REFRESH and self-refresh entry are illegal while any bank is open.
- R8: PRECHARGE with addr[10]=0 closes only the addressed bank. With addr[10]=1 it closes every bank, whatever the bank address.
- R9: After a legal MRS, any command other than NOP or DESELECT on the next 2 sampled edges is illegal.
- R10: READ and WRITE are illegal to an idle bank.
- R11: After a legal READ-AP or WRITE-AP, any READ or WRITE on the next 3 edges (BURST_CYCLES-1) is illegal. The auto-precharged bank closes at the third of those edges, and other commands on that edge still take effect.
- R12: When clock enable falls, POWER-DOWN-ENTRY (14) is reported. `pwr_mode` becomes 1 if all banks are idle and 2 if any is open. While clock enable stays low, NOP is reported and the pins are ignored. When it rises, POWER-DOWN-EXIT (15) is reported and `pwr_mode` returns to 0.
- R13: Clock enable falling together with a REFRESH pattern is SELF-REFRESH-ENTRY (4) and sets `pwr_mode` to 3. If a bank is open, the command is illegal and the mode becomes 2. When clock enable rises from self refresh, SELF-REFRESH-EXIT (5) is reported and the mode becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row/column address; bit 10 selects auto precharge or precharge-all |
| cmd_code | output | 4 | Decoded command of the previous edge |
| cmd_err | output | 1 | Previous command was illegal |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| open_rows | output | 52 | Open row of each bank, 13 bits per bank |
| pwr_mode | output | 2 | 0 running, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
Two functions can change the bank map on the same edge: the timed close at the end of an auto-precharge burst window, and a freshly accepted command. The bench sets this up by issuing READ-AP to bank 0. It tries a WRITE inside the window and waits with a NOP. It then lands an ACTIVATE to bank 2 on exactly the edge where the window expires. The result is judged through `bank_open`: bank 0 must close and bank 2 must open together, the ACTIVATE must carry no error, and a READ on the following edge must be accepted again.

// File: rtl/ddrct_pkg.sv
package ddrct_pkg;
  typedef enum logic [3:0] {
    C_NOP   = 4'd0,  C_DESEL = 4'd1,  C_MRS  = 4'd2,  C_REF  = 4'd3,
    C_SRE   = 4'd4,  C_SRX   = 4'd5,  C_ACT  = 4'd6,  C_RD   = 4'd7,
    C_RDA   = 4'd8,  C_WR    = 4'd9,  C_WRA  = 4'd10, C_BST  = 4'd11,
    C_PRE   = 4'd12, C_PREA  = 4'd13, C_PDE  = 4'd14, C_PDX  = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    P_RUN = 2'd0, P_PPD = 2'd1, P_APD = 2'd2, P_SREF = 2'd3
  } pwr_e;
endpackage

// File: rtl/ddrct_decode.sv
module ddrct_decode
  import ddrct_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_q,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            ap_pin,
  input  logic            in_sref,
  input  logic [BA_W-1:0] ba,
  output cmd_e            cmd,
  output logic [BA_W-1:0] bank_idx
);
  // bank index is the bank address with its bits reversed
  for (genvar i = 0; i < BA_W; i++) begin : g_rev
    assign bank_idx[i] = ba[BA_W-1-i];
  end

  always_comb begin
    cmd = C_NOP;
    if (cke_q && !cke) begin
      cmd = (!cs_n && {ras_n, cas_n, we_n} == 3'b001) ? C_SRE : C_PDE;
    end else if (!cke_q && cke) begin
      cmd = in_sref ? C_SRX : C_PDX;
    end else if (!cke_q) begin
      cmd = C_NOP;
    end else if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = C_MRS;
        3'b001:  cmd = C_REF;
        3'b010:  cmd = ap_pin ? C_PREA : C_PRE;
        3'b011:  cmd = C_ACT;
        3'b100:  cmd = ap_pin ? C_WRA : C_WR;
        3'b101:  cmd = ap_pin ? C_RDA : C_RD;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddrct_bank.sv
module ddrct_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end else if (close_en) begin
      is_open <= 1'b0;
    end
  end
endmodule

// File: rtl/ddrct_wincnt.sv
module ddrct_wincnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddrct_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 13,
  parameter int AP_BIT       = 10,
  parameter int MRS_GAP      = 2,
  parameter int BURST_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic [ROW_W-1:0]             addr,
  output logic [3:0]                   cmd_code,
  output logic                         cmd_err,
  output logic [NUM_BANKS-1:0]         bank_open,
  output logic [NUM_BANKS*ROW_W-1:0]   open_rows,
  output logic [1:0]                   pwr_mode
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int GAP_W = $clog2(MRS_GAP + 1);
  localparam int BST_W = $clog2(BURST_CYCLES);

  logic            cke_q;
  pwr_e            pwr_q, pwr_d;
  cmd_e            cmd, cmd_q;
  logic            err_q;
  logic [BA_W-1:0] bank_idx, ap_bank;
  logic            mrs_busy, mrs_last_unused;
  logic            ap_busy, ap_last;
  logic            all_idle, tgt_open, quiet, need_idle, is_col, illegal, accept;
  logic            mrs_load, ap_load;
  logic [NUM_BANKS-1:0] open_en, close_en;

  ddrct_decode #(.BA_W(BA_W)) u_dec (
    .cke_q   (cke_q),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ap_pin  (addr[AP_BIT]),
    .in_sref (pwr_q == P_SREF),
    .ba      (ba),
    .cmd     (cmd),
    .bank_idx(bank_idx)
  );

  // legality of the sampled command against bank state and windows
  always_comb begin
    all_idle  = (bank_open == '0);
    tgt_open  = bank_open[bank_idx];
    quiet     = (cmd == C_NOP) || (cmd == C_DESEL);
    need_idle = (cmd == C_MRS) || (cmd == C_REF) || (cmd == C_SRE);
    is_col    = (cmd == C_RD) || (cmd == C_RDA) || (cmd == C_WR) || (cmd == C_WRA);
    illegal   = (mrs_busy && !quiet)
             || (need_idle && !all_idle)
             || ((cmd == C_ACT) && tgt_open)
             || (is_col && (!tgt_open || ap_busy));
    accept    = !illegal;
    mrs_load  = accept && (cmd == C_MRS);
    ap_load   = accept && ((cmd == C_RDA) || (cmd == C_WRA));
  end

  // per-bank open and close strobes
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      open_en[i]  = accept && (cmd == C_ACT) && (bank_idx == BA_W'(i));
      close_en[i] = (accept && (((cmd == C_PRE) && (bank_idx == BA_W'(i)))
                                || (cmd == C_PREA)))
                 || (ap_last && (ap_bank == BA_W'(i)));
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ddrct_bank #(.ROW_W(ROW_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_en (open_en[g]),
      .close_en(close_en[g]),
      .row_in  (addr),
      .is_open (bank_open[g]),
      .row_q   (open_rows[g*ROW_W +: ROW_W])
    );
  end

  ddrct_wincnt #(.CNT_W(GAP_W)) u_mrs_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mrs_load),
    .load_val(GAP_W'(MRS_GAP)),
    .busy    (mrs_busy),
    .last    (mrs_last_unused)
  );

  ddrct_wincnt #(.CNT_W(BST_W)) u_ap_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ap_load),
    .load_val(BST_W'(BURST_CYCLES - 1)),
    .busy    (ap_busy),
    .last    (ap_last)
  );

  // power mode follows the clock-enable transitions
  always_comb begin
    pwr_d = pwr_q;
    case (cmd)
      C_SRE:         pwr_d = illegal ? (all_idle ? P_PPD : P_APD) : P_SREF;
      C_PDE:         pwr_d = all_idle ? P_PPD : P_APD;
      C_SRX, C_PDX:  pwr_d = P_RUN;
      default:       pwr_d = pwr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      pwr_q   <= P_RUN;
      cmd_q   <= C_NOP;
      err_q   <= 1'b0;
      ap_bank <= '0;
    end else begin
      cke_q <= cke;
      pwr_q <= pwr_d;
      cmd_q <= cmd;
      err_q <= illegal;
      if (ap_load) ap_bank <= bank_idx;
    end
  end

  assign cmd_code = cmd_q;
  assign cmd_err  = err_q;
  assign pwr_mode = pwr_q;
endmodule

// File: rtl/ddrct_chk.sv
module ddrct_chk
  import ddrct_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           cmd_code,
  input logic                 cmd_err,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [1:0]           pwr_mode
);
  // R6
  err_keeps_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> bank_open == $past(bank_open));

  // R4
  open_only_by_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_open & ~$past(bank_open)) != '0) |-> (cmd_code == C_ACT));

  // R7
  refresh_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_REF && !cmd_err) |-> ($past(bank_open) == '0));

  // R9
  mrs_quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == C_MRS && !cmd_err) |=>
      (cmd_code == C_NOP || cmd_code == C_DESEL || cmd_err));

  // R13
  sref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == P_SREF) |-> (bank_open == '0));
endmodule

bind ddr_cmd_tracker ddrct_chk #(.NUM_BANKS(NUM_BANKS)) u_ddrct_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_code (cmd_code),
  .cmd_err  (cmd_err),
  .bank_open(bank_open),
  .pwr_mode (pwr_mode)
);

// File: tb/tb_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr_cmd_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_code;
  logic        cmd_err;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic [1:0]  pwr_mode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .cmd_err(cmd_err), .bank_open(bank_open), .open_rows(open_rows),
    .pwr_mode(pwr_mode)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drv(input logic k, input logic cs, input logic [2:0] rcw,
                     input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic cmd_chk(input string tag, input int code, input int err);
    check({tag, " code"}, int'(cmd_code), code);
    check({tag, " err"}, int'(cmd_err), err);
  endtask

  function automatic int bidx(input int b);
    return ((b & 1) << 1) | (b >> 1);
  endfunction

  function automatic int row_of(input int i);
    return int'(open_rows[i*13 +: 13]);
  endfunction

  localparam logic [12:0] AP = 13'd1 << 10;

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int exp_code [8] = '{2, 3, 12, 6, 9, 7, 11, 0};
    int exp_err  [8] = '{0, 0, 0, 0, 1, 1, 0, 0};
    int mask;
    rst_n = 1'b0;
    cke = 1; cs_n = 0; {ras_n, cas_n, we_n} = 3'b111; ba = 0; addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 banks", int'(bank_open), 0);
    cmd_chk("R1", 0, 0);
    check("R1 pwr", int'(pwr_mode), 0);

    // R2 deselect sweep
    for (int r = 0; r < 8; r++) begin
      drv(1, 1, 3'(r), 2'(r & 3), 13'h1FFF);
      cmd_chk("R2 deselect", 1, 0);
      check("R2 banks", int'(bank_open), 0);
    end

    // R3 decode sweep with all banks idle
    for (int r = 0; r < 8; r++) begin
      drv(1, 0, 3'(r), 2'd0, 13'h0);
      cmd_chk("R3 decode", exp_code[r], exp_err[r]);
      if (r == 0) begin drv(1, 0, 3'b111, 0, 0); drv(1, 0, 3'b111, 0, 0); end
      if (r == 3) begin
        check("R3 act opens", int'(bank_open), 1);
        drv(1, 0, 3'b010, 0, AP);
      end
    end
    drv(1, 0, 3'b010, 2'd0, AP);
    cmd_chk("R3 prea", 13, 0);
    drv(1, 0, 3'b011, 2'd0, 13'h0);
    drv(1, 0, 3'b101, 2'd0, AP);
    cmd_chk("R3 rda", 8, 0);
    drv(1, 0, 3'b111, 0, 0); drv(1, 0, 3'b111, 0, 0); drv(1, 0, 3'b111, 0, 0);
    drv(1, 0, 3'b100, 2'd0, AP);
    cmd_chk("R3 wra on idle bank", 10, 1);

    // R4 bank address mapping and row capture
    mask = 0;
    for (int b = 0; b < 4; b++) begin
      drv(1, 0, 3'b011, 2'(b), 13'(16'h0F0 + b * 16'h111));
      mask |= 1 << bidx(b);
      cmd_chk("R4 act", 6, 0);
      check("R4 open map", int'(bank_open), mask);
      check("R4 row", row_of(bidx(b)), 'h0F0 + b * 'h111);
    end

    // R5 R6 activate of open bank
    drv(1, 0, 3'b011, 2'd0, 13'd5);
    cmd_chk("R5 act open bank", 6, 1);
    check("R6 row kept", row_of(0), 'h0F0);
    check("R6 banks kept", int'(bank_open), 15);

    // R7 all-idle rule
    drv(1, 0, 3'b001, 2'd0, 13'd0);
    cmd_chk("R7 ref open", 3, 1);
    drv(1, 0, 3'b000, 2'd0, 13'd0);
    cmd_chk("R7 mrs open", 2, 1);
    check("R7 banks kept", int'(bank_open), 15);

    // R8 single and all precharge
    drv(1, 0, 3'b010, 2'b01, 13'd0);
    cmd_chk("R8 pre", 12, 0);
    check("R8 single close", int'(bank_open), 4'hB);
    drv(1, 0, 3'b010, 2'b01, AP);
    check("R8 all close", int'(bank_open), 0);

    // R9 mode set gap
    drv(1, 0, 3'b000, 2'd0, 13'd0);
    cmd_chk("R9 mrs", 2, 0);
    drv(1, 0, 3'b011, 2'd0, 13'd7);
    cmd_chk("R9 gap1", 6, 1);
    drv(1, 0, 3'b011, 2'd0, 13'd7);
    cmd_chk("R9 gap2", 6, 1);
    check("R9 banks idle", int'(bank_open), 0);
    drv(1, 0, 3'b011, 2'd0, 13'd7);
    cmd_chk("R9 after gap", 6, 0);
    check("R9 opened", int'(bank_open), 1);

    // R10 column commands
    drv(1, 0, 3'b011, 2'b10, 13'd9);
    check("R10 bank1 open", int'(bank_open), 3);
    drv(1, 0, 3'b101, 2'd0, 13'd0);
    cmd_chk("R10 rd", 7, 0);
    drv(1, 0, 3'b100, 2'b10, 13'd0);
    cmd_chk("R10 wr", 9, 0);
    drv(1, 0, 3'b101, 2'b11, 13'd0);
    cmd_chk("R10 rd idle", 7, 1);

    // R11 auto-precharge window, close coinciding with activate
    drv(1, 0, 3'b101, 2'd0, AP);
    cmd_chk("R11 rda", 8, 0);
    check("R11 still open", int'(bank_open), 3);
    drv(1, 0, 3'b100, 2'b10, 13'd0);
    cmd_chk("R11 wr in window", 9, 1);
    drv(1, 0, 3'b111, 2'd0, 13'd0);
    check("R11 open mid", int'(bank_open), 3);
    drv(1, 0, 3'b011, 2'b01, 13'd3);
    cmd_chk("R11 act at close", 6, 0);
    check("R11 close and open", int'(bank_open), 6);
    drv(1, 0, 3'b101, 2'b10, 13'd0);
    cmd_chk("R11 rd after", 7, 0);
    drv(1, 0, 3'b010, 2'd0, AP);
    check("R11 cleanup", int'(bank_open), 0);

    // R12 power-down
    drv(0, 0, 3'b111, 2'd0, 13'd0);
    cmd_chk("R12 pde", 14, 0);
    check("R12 ppd", int'(pwr_mode), 1);
    drv(0, 0, 3'b011, 2'd0, 13'd0);
    cmd_chk("R12 ignored", 0, 0);
    check("R12 ignored banks", int'(bank_open), 0);
    drv(1, 0, 3'b111, 2'd0, 13'd0);
    cmd_chk("R12 pdx", 15, 0);
    check("R12 run", int'(pwr_mode), 0);
    drv(1, 0, 3'b011, 2'd0, 13'd1);
    drv(0, 0, 3'b111, 2'd0, 13'd0);
    check("R12 apd", int'(pwr_mode), 2);
    drv(1, 0, 3'b111, 2'd0, 13'd0);
    check("R12 exit apd", int'(pwr_mode), 0);

    // R13 self refresh
    drv(0, 0, 3'b001, 2'd0, 13'd0);
    cmd_chk("R13 sre open", 4, 1);
    check("R13 fallback apd", int'(pwr_mode), 2);
    check("R13 banks kept", int'(bank_open), 1);
    drv(1, 0, 3'b111, 2'd0, 13'd0);
    drv(1, 0, 3'b010, 2'd0, AP);
    drv(0, 0, 3'b001, 2'd0, 13'd0);
    cmd_chk("R13 sre", 4, 0);
    check("R13 sref", int'(pwr_mode), 3);
    drv(0, 0, 3'b111, 2'd0, 13'd0);
    check("R13 hold", int'(pwr_mode), 3);
    drv(1, 0, 3'b111, 2'd0, 13'd0);
    cmd_chk("R13 srx", 5, 0);
    check("R13 run", int'(pwr_mode), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule